// File: doc/BRIEF.md
# Masked Repeating Alarm Controller

This block holds the alarm settings of a real-time clock and raises an interrupt when the running time matches them. Four byte-wide compare registers keep a BCD alarm second, minute, hour and day of month. The block does no time counting of its own. An external counter supplies the present time as BCD fields, together with a one-cycle strobe once per second. On each strobe the block compares the stored alarm against that time.

Bit 7 of each compare register is a "don't care" mask for its field. The masks are not free per field. The combination of the four mask bits selects one of five repeat rates: monthly, daily, hourly, once a minute or every second. Writes over the byte bus are range-checked the way a clock register would be, and a rejected write leaves the old contents in place. An interrupt-control byte at the next offset stores eight freely usable bits. Its bit 7 gates the interrupt pulse.

Top module: `alarm_unit`

## Requirements
- R1: After reset every register reads 0x00 and alarm_irq is low.
- R2: A write to offset 0 (seconds) or offset 1 (minutes) is stored as the full byte, including bit 7, only when tens*10+units of its low 7 bits is at most 59. Here tens is bits 6:4 and units is bits 3:0, so 0x0A counts as 10. Otherwise the register keeps its old value.
- R3: A write to offset 2 (hours) is stored as the full byte only when tens*10+units of its low 6 bits is at most 23. Otherwise it is ignored.
- R4: A write to offset 3 (date) is stored as the full byte only when its low 5 bits are nonzero. Otherwise it is ignored.
- R5: Offset 4 is the control byte. It stores and reads back all 8 bits, and its bit 7 enables the interrupt. Offsets 5 to 7 read 0x00 and ignore writes.
- R6: With no mask bit set, a second strobe fires the alarm only when second, minute, hour and date all match. The comparison uses bits 6:0 of seconds and minutes and bits 5:0 of hours and date.
- R7: With only the date mask set, a strobe fires the alarm when second, minute and hour match, whatever the date.
- R8: With the date and hour masks set, and the others clear, a strobe fires the alarm when second and minute match.
- R9: With the date, hour and minute masks set, and the seconds mask clear, a strobe fires the alarm when the second matches.
- R10: Any other mask combination fires the alarm on every second strobe.
- R11: When the alarm fires on a strobe cycle with control bit 7 set, alarm_irq is high for exactly the following cycle. Without a strobe, or with bit 7 clear, alarm_irq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register, combinational |
| sec_tick | input | 1 | One-cycle strobe once per second |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD |
| now_date | input | 6 | Current day of month, BCD |
| alarm_irq | output | 1 | Alarm interrupt pulse |

## Verification
A write lands at the clock edge where bus_we is high. Read data follows bus_addr with no delay, so the bench reads a register back one cycle after writing it. alarm_irq is registered from the strobe cycle and is due one edge after sec_tick. The bench raises the strobe at a falling edge and samples the interrupt at the next falling edge. It samples once more a cycle later to confirm that the pulse has ended.

// File: rtl/alarm_unit.sv
module alarm_unit #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          sec_tick,
  input  logic [6:0]    now_sec,
  input  logic [6:0]    now_min,
  input  logic [5:0]    now_hour,
  input  logic [5:0]    now_date,
  output logic          alarm_irq
);
  localparam logic [AW-1:0] OFS_SEC  = AW'(0);
  localparam logic [AW-1:0] OFS_MIN  = AW'(1);
  localparam logic [AW-1:0] OFS_HOUR = AW'(2);
  localparam logic [AW-1:0] OFS_DATE = AW'(3);
  localparam logic [AW-1:0] OFS_CTL  = AW'(4);

  logic [7:0] alm_sec, alm_min, alm_hour, alm_date, ctl_reg;
  logic       hit;

  function automatic logic [6:0] bcd_val(input logic [6:0] b);
    return {4'd0, b[6:4]} * 7'd10 + {3'd0, b[3:0]};
  endfunction

  wire ok_ms   = bcd_val(bus_wdata[6:0]) <= 7'd59;
  wire ok_hour = bcd_val({1'b0, bus_wdata[5:0]}) <= 7'd23;
  wire ok_date = bus_wdata[4:0] != 5'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_sec  <= 8'h00;
      alm_min  <= 8'h00;
      alm_hour <= 8'h00;
      alm_date <= 8'h00;
      ctl_reg  <= 8'h00;
    end else if (bus_we) begin
      if (bus_addr == OFS_SEC  && ok_ms)   alm_sec  <= bus_wdata;
      if (bus_addr == OFS_MIN  && ok_ms)   alm_min  <= bus_wdata;
      if (bus_addr == OFS_HOUR && ok_hour) alm_hour <= bus_wdata;
      if (bus_addr == OFS_DATE && ok_date) alm_date <= bus_wdata;
      if (bus_addr == OFS_CTL)             ctl_reg  <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_SEC:  bus_rdata = alm_sec;
      OFS_MIN:  bus_rdata = alm_min;
      OFS_HOUR: bus_rdata = alm_hour;
      OFS_DATE: bus_rdata = alm_date;
      OFS_CTL:  bus_rdata = ctl_reg;
      default:  bus_rdata = 8'h00;
    endcase
  end

  wire eq_s = alm_sec[6:0]  == now_sec;
  wire eq_m = alm_min[6:0]  == now_min;
  wire eq_h = alm_hour[5:0] == now_hour;
  wire eq_d = alm_date[5:0] == now_date;
  wire [3:0] masks = {alm_date[7], alm_hour[7], alm_min[7], alm_sec[7]};

  always_comb begin
    case (masks)
      4'b0000: hit = eq_s & eq_m & eq_h & eq_d;
      4'b1000: hit = eq_s & eq_m & eq_h;
      4'b1100: hit = eq_s & eq_m;
      4'b1110: hit = eq_s;
      default: hit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) alarm_irq <= 1'b0;
    else        alarm_irq <= sec_tick & ctl_reg[7] & hit;
  end
endmodule

module alarm_unit_checker #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          sec_tick,
  input logic [7:0]    ctl_reg,
  input logic [7:0]    alm_sec,
  input logic [7:0]    alm_min,
  input logic [7:0]    alm_hour,
  input logic [7:0]    alm_date,
  input logic          alarm_irq
);
  wire [6:0] tens  = {4'd0, bus_wdata[6:4]};
  wire [6:0] units = {3'd0, bus_wdata[3:0]};
  wire [6:0] htens = {5'd0, bus_wdata[5:4]};

  AST_SEC_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(0) && (tens * 7'd10 + units) > 7'd59) |=> $stable(alm_sec)); // R2
  AST_MIN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(1) && (tens * 7'd10 + units) > 7'd59) |=> $stable(alm_min)); // R2
  AST_HOUR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(2) && (htens * 7'd10 + units) > 7'd23) |=> $stable(alm_hour)); // R3
  AST_DATE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(3) && bus_wdata[4:0] == 5'd0) |=> $stable(alm_date)); // R4
  AST_CTL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(4)) |=> ctl_reg == $past(bus_wdata)); // R5
  AST_ALL_MASKED_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && ctl_reg[7] && alm_sec[7] && alm_min[7] && alm_hour[7] && alm_date[7]) |=> alarm_irq); // R10
  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> !alarm_irq); // R11
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> $past(ctl_reg[7])); // R11
endmodule

bind alarm_unit alarm_unit_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .sec_tick(sec_tick), .ctl_reg(ctl_reg),
  .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
  .alm_date(alm_date), .alarm_irq(alarm_irq)
);

// File: tb/alarm_unit_bench.sv
module alarm_unit_bench;
  localparam int CLK_P = 10;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic sec_tick = 1'b0;
  logic [6:0] now_sec = '0;
  logic [6:0] now_min = '0;
  logic [5:0] now_hour = '0;
  logic [5:0] now_date = '0;
  logic alarm_irq;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  alarm_unit #(.AW(AW)) u_alarm_unit (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_tick(sec_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_date(now_date), .alarm_irq(alarm_irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic fire(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                      input logic [5:0] d, output logic irq);
    @(negedge clk);
    now_sec = s; now_min = m; now_hour = h; now_date = d; sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    irq = alarm_irq;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(AW'(a), v);
      check("R1 reset register", v, 8'h00);
    end
    check("R1 reset irq", {7'd0, alarm_irq}, 8'h00);
    rst_n = 1'b1;
  endtask

  task automatic t_ranges;
    logic [7:0] v;
    wr(0, 8'h59); rd(0, v); check("R2 sec 59 accepted", v, 8'h59);
    wr(0, 8'h5A); rd(0, v); check("R2 sec 60 rejected", v, 8'h59);
    wr(0, 8'h0A); rd(0, v); check("R2 sec 0x0A accepted as 10", v, 8'h0A);
    wr(0, 8'hD9); rd(0, v); check("R2 sec with mask stored", v, 8'hD9);
    wr(1, 8'h60); rd(1, v); check("R2 min 60 rejected", v, 8'h00);
    wr(1, 8'h45); rd(1, v); check("R2 min 45 accepted", v, 8'h45);
    wr(2, 8'h23); rd(2, v); check("R3 hour 23 accepted", v, 8'h23);
    wr(2, 8'h24); rd(2, v); check("R3 hour 24 rejected", v, 8'h23);
    wr(2, 8'h9F); rd(2, v); check("R3 hour 25 rejected", v, 8'h23);
    wr(2, 8'h63); rd(2, v); check("R3 hour bit6 ignored in range", v, 8'h63);
    wr(3, 8'h31); rd(3, v); check("R4 date 0x31 accepted", v, 8'h31);
    wr(3, 8'h20); rd(3, v); check("R4 date low zero rejected", v, 8'h31);
  endtask

  task automatic t_ctl;
    logic [7:0] v;
    wr(4, 8'h5A); rd(4, v); check("R5 control stores byte", v, 8'h5A);
    wr(5, 8'hFF); rd(5, v); check("R5 offset 5 reads zero", v, 8'h00);
    wr(7, 8'hFF); rd(7, v); check("R5 offset 7 reads zero", v, 8'h00);
    rd(4, v); check("R5 control untouched", v, 8'h5A);
  endtask

  task automatic set_alarm(input logic [7:0] s, input logic [7:0] m,
                           input logic [7:0] h, input logic [7:0] d);
    wr(0, s); wr(1, m); wr(2, h); wr(3, d);
  endtask

  task automatic t_month;
    logic irq;
    wr(4, 8'h80);
    set_alarm(8'h30, 8'h15, 8'h10, 8'h12);
    fire(7'h30, 7'h15, 6'h10, 6'h12, irq); check("R6 full match fires", {7'd0, irq}, 8'h01);
    fire(7'h30, 7'h15, 6'h10, 6'h13, irq); check("R6 date differs", {7'd0, irq}, 8'h00);
    fire(7'h31, 7'h15, 6'h10, 6'h12, irq); check("R6 second differs", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_day;
    logic irq;
    set_alarm(8'h30, 8'h15, 8'h10, 8'h92);
    fire(7'h30, 7'h15, 6'h10, 6'h05, irq); check("R7 other date fires", {7'd0, irq}, 8'h01);
    fire(7'h30, 7'h15, 6'h11, 6'h12, irq); check("R7 hour differs", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_hour;
    logic irq;
    set_alarm(8'h30, 8'h15, 8'h90, 8'h92);
    fire(7'h30, 7'h15, 6'h03, 6'h05, irq); check("R8 other hour fires", {7'd0, irq}, 8'h01);
    fire(7'h30, 7'h16, 6'h10, 6'h12, irq); check("R8 minute differs", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_minute;
    logic irq;
    set_alarm(8'h30, 8'h95, 8'h90, 8'h92);
    fire(7'h30, 7'h44, 6'h03, 6'h05, irq); check("R9 other minute fires", {7'd0, irq}, 8'h01);
    fire(7'h29, 7'h15, 6'h10, 6'h12, irq); check("R9 second differs", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_second;
    logic irq;
    set_alarm(8'hB0, 8'h15, 8'h10, 8'h12);
    fire(7'h01, 7'h02, 6'h03, 6'h04, irq); check("R10 seconds-only mask fires", {7'd0, irq}, 8'h01);
    set_alarm(8'h30, 8'h95, 8'h10, 8'h92);
    fire(7'h01, 7'h02, 6'h03, 6'h04, irq); check("R10 gap mask fires", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_pulse;
    logic irq;
    set_alarm(8'h30, 8'h15, 8'h10, 8'h12);
    fire(7'h30, 7'h15, 6'h10, 6'h12, irq); check("R11 pulse high", {7'd0, irq}, 8'h01);
    @(negedge clk); check("R11 pulse one cycle", {7'd0, alarm_irq}, 8'h00);
    @(negedge clk); check("R11 no tick quiet", {7'd0, alarm_irq}, 8'h00);
    wr(4, 8'h7F);
    fire(7'h30, 7'h15, 6'h10, 6'h12, irq); check("R11 disabled no irq", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    #(CLK_P * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_ranges();
    t_ctl();
    t_month();
    t_day();
    t_hour();
    t_minute();
    t_second();
    t_pulse();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule